// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block sits in the fetch stage and guesses, for every fetch address presented to it, whether the instruction there is a branch that will be taken and, if so, where fetch should go next. It holds a small direct-mapped buffer of branches it has already seen. Each entry keeps that branch's last few outcomes. On a hit, those outcomes select a shared table of two-bit saturating counters, and the selected counter gives the direction.

When the address is not in the buffer, the block falls back to fixed rules driven by the branch kind and the displacement sign that the decoder supplies. Unconditional jumps are taken. Backward conditional branches are taken. Forward conditional branches and non-branches fall through.

The prediction is registered, so a taken guess redirects fetch one clock after the lookup. The execute stage reports each resolved branch back through a resolve port. That report trains history, counters and targets, allocates entries for taken branches that missed, and raises a one-cycle mispredict pulse when the outcome disagrees with the prediction it carried. A flush pulse cancels the prediction still in flight.

Top module: `btb_predictor`

## Requirements
- R1: After reset every buffer entry is invalid, every pattern counter holds 2'b10, and pred_valid, pred_hit, pred_taken, pred_target and mispredict are all zero.
- R2: A lookup with fetch_valid high and flush low in cycle N shows its result in cycle N+1 with pred_valid high. Without a fetch, pred_valid, pred_hit, pred_taken and pred_target are zero in cycle N+1.
- R3: On a buffer miss, fetch_kind 2'b10 (unconditional) predicts taken with target fetch_pc + fetch_disp. Kinds 2'b00 and 2'b11 (not a branch) predict not taken.
- R4: On a buffer miss, fetch_kind 2'b01 (conditional) with fetch_disp negative (top bit set) predicts taken with target fetch_pc + fetch_disp.
- R5: On a buffer miss, a conditional branch with zero or positive fetch_disp predicts not taken. Every not-taken prediction has pred_target zero.
- R6: An entry hits when it is valid and its tag (fetch_pc above the low IDX_W index bits) matches. On a hit, pred_hit is 1, the direction is the top bit of the counter selected by the entry's history, the target is the stored target, and fetch_kind and fetch_disp have no effect.
- R7: A resolved taken branch that misses allocates its entry (index = low IDX_W bits of res_pc) with the full tag, res_target, and history all ones. A resolved not-taken miss leaves the buffer unchanged.
- R8: A resolved hit shifts the entry history left with res_taken entering bit 0. It also moves the counter selected by the old history one step toward the outcome, saturating at 0 and 3.
- R9: A resolved taken hit rewrites the stored target with res_target. A not-taken hit keeps it.
- R10: mispredict is high for exactly the cycle after a resolve in which res_taken differs from res_pred_taken, or both are taken and res_target differs from res_pred_target.
- R11: flush high in a lookup cycle cancels that lookup: pred_valid is zero in the next cycle.
- R12: A lookup and a resolve in the same cycle make the lookup see the buffer and counters as they were before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | Lookup request |
| fetch_pc | input | ADDR_W | Fetch address |
| fetch_kind | input | 2 | Decoded kind: 00/11 none, 01 conditional, 10 unconditional |
| fetch_disp | input | ADDR_W | Signed branch displacement |
| flush | input | 1 | Cancels the lookup of this cycle |
| res_valid | input | 1 | Resolved branch report |
| res_pc | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Actual direction |
| res_target | input | ADDR_W | Actual target |
| res_pred_taken | input | 1 | Direction that was predicted |
| res_pred_target | input | ADDR_W | Target that was predicted |
| pred_valid | output | 1 | Prediction present |
| pred_hit | output | 1 | Prediction came from the buffer |
| pred_taken | output | 1 | Predicted taken |
| pred_target | output | ADDR_W | Predicted target, zero when not taken |
| mispredict | output | 1 | One-cycle misprediction pulse |

## Verification
The bench builds the block with ADDR_W of 12, IDX_W of 4 and HIST_W of 4. The narrow address leaves an eight-bit tag, so random lookups drawn from three tags over all sixteen indices keep producing aliasing misses, replacements and repeat hits on the same entry. With a four-bit history, a few resolves of one branch are enough to walk its history through every pattern and drive the shared counters into both saturation limits.

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic [1:0]        fetch_kind,
  input  logic [ADDR_W-1:0] fetch_disp,
  input  logic              flush,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  input  logic              res_pred_taken,
  input  logic [ADDR_W-1:0] res_pred_target,
  output logic              pred_valid,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  output logic              mispredict
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int PATS    = 1 << HIST_W;
  localparam int TAG_W   = ADDR_W - IDX_W;
  localparam logic [1:0] KIND_COND = 2'b01;
  localparam logic [1:0] KIND_JUMP = 2'b10;

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q  [ENTRIES];
  logic [HIST_W-1:0]  hist_q [ENTRIES];
  logic [1:0]         cnt_q  [PATS];

  logic [IDX_W-1:0]  f_idx;
  logic              f_hit, f_taken, static_taken, lookup;
  logic [ADDR_W-1:0] f_target;

  assign f_idx  = fetch_pc[IDX_W-1:0];
  assign f_hit  = vld[f_idx] && (tag_q[f_idx] == fetch_pc[ADDR_W-1:IDX_W]);
  assign static_taken = (fetch_kind == KIND_JUMP) ||
                        ((fetch_kind == KIND_COND) && fetch_disp[ADDR_W-1]);
  assign f_taken  = f_hit ? cnt_q[hist_q[f_idx]][1] : static_taken;
  assign f_target = !f_taken ? '0 : (f_hit ? tgt_q[f_idx] : fetch_pc + fetch_disp);
  assign lookup   = fetch_valid && !flush;

  logic [IDX_W-1:0]  r_idx;
  logic              r_hit;
  logic [HIST_W-1:0] r_hist;
  logic [1:0]        r_cnt, r_cnt_nxt;

  assign r_idx  = res_pc[IDX_W-1:0];
  assign r_hit  = vld[r_idx] && (tag_q[r_idx] == res_pc[ADDR_W-1:IDX_W]);
  assign r_hist = hist_q[r_idx];
  assign r_cnt  = cnt_q[r_hist];

  always_comb begin
    r_cnt_nxt = r_cnt;
    if (res_taken) begin
      if (r_cnt != 2'b11) r_cnt_nxt = r_cnt + 2'b01;
    end else begin
      if (r_cnt != 2'b00) r_cnt_nxt = r_cnt - 2'b01;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        tgt_q[i]  <= '0;
        hist_q[i] <= '0;
      end
      for (int p = 0; p < PATS; p++) cnt_q[p] <= 2'b10;
    end else if (res_valid) begin
      if (r_hit) begin
        hist_q[r_idx] <= {r_hist[HIST_W-2:0], res_taken};
        cnt_q[r_hist] <= r_cnt_nxt;
        if (res_taken) tgt_q[r_idx] <= res_target;
      end else if (res_taken) begin
        vld[r_idx]    <= 1'b1;
        tag_q[r_idx]  <= res_pc[ADDR_W-1:IDX_W];
        tgt_q[r_idx]  <= res_target;
        hist_q[r_idx] <= '1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_valid  <= 1'b0;
      pred_hit    <= 1'b0;
      pred_taken  <= 1'b0;
      pred_target <= '0;
      mispredict  <= 1'b0;
    end else begin
      pred_valid  <= lookup;
      pred_hit    <= lookup && f_hit;
      pred_taken  <= lookup && f_taken;
      pred_target <= lookup ? f_target : '0;
      mispredict  <= res_valid && ((res_taken != res_pred_taken) ||
                     (res_taken && (res_target != res_pred_target)));
    end
  end

  // R2
  pred_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> $past(fetch_valid));

  // R11
  flush_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pred_valid);

  // R10
  mispredict_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> $past(res_valid));

  // R7
  taken_resolve_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken) |=> vld[$past(r_idx)]);

  // R3
  jump_miss_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !pred_hit && $past(fetch_kind) == KIND_JUMP) |-> pred_taken);

  // R5
  not_taken_zero_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_taken |-> (pred_target == '0));

  // R6
  hit_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_hit || pred_taken) |-> pred_valid);
endmodule

// File: tb/sim_btb_predictor.sv
module sim_btb_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int IW = 4;
  localparam int HW = 4;
  localparam int NE = 1 << IW;
  localparam int NP = 1 << HW;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n;
  logic          fv, fl, rv, rt, rpt;
  logic [AW-1:0] fpc, fdisp, rpc, rtg, rptg;
  logic [1:0]    fkind;
  logic          pred_valid, pred_hit, pred_taken, mispredict;
  logic [AW-1:0] pred_target;

  btb_predictor #(.ADDR_W(AW), .IDX_W(IW), .HIST_W(HW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fv), .fetch_pc(fpc), .fetch_kind(fkind), .fetch_disp(fdisp),
    .flush(fl),
    .res_valid(rv), .res_pc(rpc), .res_taken(rt), .res_target(rtg),
    .res_pred_taken(rpt), .res_pred_target(rptg),
    .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_taken(pred_taken),
    .pred_target(pred_target), .mispredict(mispredict)
  );

  bit            m_vld  [NE];
  logic [AW-1:0] m_pc   [NE];
  logic [AW-1:0] m_tgt  [NE];
  logic [HW-1:0] m_hist [NE];
  logic [1:0]    m_cnt  [NP];

  int checks = 0;
  int fails  = 0;

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NE; i++) begin
      m_vld[i] = 0; m_pc[i] = '0; m_tgt[i] = '0; m_hist[i] = '0;
    end
    for (int p = 0; p < NP; p++) m_cnt[p] = 2'b10;
  endtask

  task automatic model_predict(output logic h, output logic t, output logic [AW-1:0] g);
    int i;
    i = int'(fpc[IW-1:0]);
    h = m_vld[i] && (m_pc[i][AW-1:IW] == fpc[AW-1:IW]);
    if (h) t = m_cnt[m_hist[i]][1];
    else   t = (fkind == 2'b10) || (fkind == 2'b01 && fdisp[AW-1]);
    if (!t)     g = '0;
    else if (h) g = m_tgt[i];
    else        g = fpc + fdisp;
  endtask

  task automatic model_update();
    int i;
    logic [HW-1:0] h;
    logic [1:0] c;
    i = int'(rpc[IW-1:0]);
    if (m_vld[i] && (m_pc[i][AW-1:IW] == rpc[AW-1:IW])) begin
      h = m_hist[i];
      c = m_cnt[h];
      if (rt) begin if (c != 2'b11) c = c + 2'b01; end
      else begin if (c != 2'b00) c = c - 2'b01; end
      m_cnt[h]  = c;
      m_hist[i] = {h[HW-2:0], rt};
      if (rt) m_tgt[i] = rtg;
    end else if (rt) begin
      m_vld[i] = 1; m_pc[i] = rpc; m_tgt[i] = rtg; m_hist[i] = '1;
    end
  endtask

  task automatic idle();
    fv = 0; fl = 0; fpc = '0; fkind = 2'b00; fdisp = '0;
    rv = 0; rpc = '0; rt = 0; rtg = '0; rpt = 0; rptg = '0;
  endtask

  task automatic cycle(string ctx);
    logic eh, et, ev, em;
    logic [AW-1:0] eg;
    string dir;
    ev = fv && !fl;
    model_predict(eh, et, eg);
    if (eh)                                 dir = "R6";
    else if (fkind == 2'b10)                dir = "R3";
    else if (fkind == 2'b01 && fdisp[AW-1]) dir = "R4";
    else if (fkind == 2'b01)                dir = "R5";
    else                                    dir = "R3";
    if (!ev) begin eh = 0; et = 0; eg = '0; end
    em = rv && ((rt != rpt) || (rt && (rtg != rptg)));
    @(posedge clk);
    if (rv) model_update();
    @(negedge clk);
    chk({"R2 pred_valid ", ctx}, pred_valid, ev);
    chk({dir, " pred_hit ", ctx}, pred_hit, eh);
    chk({dir, " pred_taken ", ctx}, pred_taken, et);
    chk({dir, " pred_target ", ctx}, pred_target, eg);
    chk({"R10 mispredict ", ctx}, mispredict, em);
  endtask

  task automatic fetch(logic [AW-1:0] pc, logic [1:0] k, logic [AW-1:0] d);
    fv = 1; fpc = pc; fkind = k; fdisp = d;
  endtask

  task automatic resolve(logic [AW-1:0] pc, logic t, logic [AW-1:0] g, logic pt, logic [AW-1:0] pg);
    rv = 1; rpc = pc; rt = t; rtg = g; rpt = pt; rptg = pg;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    idle();
    model_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state of the outputs
    chk("R1 pred_valid", pred_valid, 0);
    chk("R1 pred_taken", pred_taken, 0);
    chk("R1 pred_target", pred_target, 0);
    chk("R1 mispredict", mispredict, 0);

    fetch(12'h120, 2'b00, 12'h020); cycle("R1 empty buffer"); idle();
    fetch(12'h200, 2'b10, 12'h040); cycle("R3 jump"); idle();
    fetch(12'h210, 2'b11, 12'hF00); cycle("R3 kind 11"); idle();
    fetch(12'h300, 2'b01, 12'hFF0); cycle("R4 backward"); idle();
    fetch(12'h310, 2'b01, 12'h010); cycle("R5 forward"); idle();
    fetch(12'h320, 2'b01, 12'h000); cycle("R5 zero disp"); idle();
    cycle("R2 no fetch");

    resolve(12'h300, 1, 12'h2F0, 1, 12'h2F0); cycle("R7 allocate"); idle();
    fetch(12'h300, 2'b00, 12'h000); cycle("R7 hit after alloc"); idle();
    fetch(12'h300, 2'b01, 12'h010); cycle("R6 kind ignored"); idle();

    for (int n = 0; n < 6; n++) begin
      resolve(12'h300, 0, 12'h000, 1, 12'h2F0); cycle("R8 train not taken"); idle();
      fetch(12'h300, 2'b10, 12'h055); cycle("R8 after training"); idle();
    end

    resolve(12'h300, 1, 12'h111, 0, 12'h000); cycle("R9 retarget"); idle();
    resolve(12'h300, 1, 12'h111, 1, 12'h2F0); cycle("R10 target differs"); idle();
    fetch(12'h300, 2'b00, 12'h000); cycle("R9 new target"); idle();

    resolve(12'h500, 0, 12'h000, 0, 12'h000); cycle("R7 no alloc"); idle();
    fetch(12'h500, 2'b00, 12'h000); cycle("R7 not-taken miss"); idle();

    fetch(12'h200, 2'b10, 12'h040); fl = 1; cycle("R11 flush"); idle();

    fetch(12'h707, 2'b00, 12'h000); resolve(12'h707, 1, 12'h0AA, 0, 12'h000);
    cycle("R12 same cycle"); idle();
    fetch(12'h707, 2'b00, 12'h000); cycle("R12 next lookup"); idle();

    for (int n = 0; n < 3000; n++) begin
      fv    = ($urandom_range(0, 3) != 0);
      fl    = ($urandom_range(0, 15) == 0);
      fpc   = AW'(($urandom_range(0, 2) << 6) | $urandom_range(0, 15));
      fkind = 2'($urandom_range(0, 3));
      fdisp = AW'($urandom);
      rv    = ($urandom_range(0, 1) == 1);
      rpc   = AW'(($urandom_range(0, 2) << 6) | $urandom_range(0, 15));
      rt    = ($urandom_range(0, 1) == 1);
      rtg   = AW'($urandom_range(0, 7) << 4);
      if ($urandom_range(0, 1) == 1) begin rpt = rt; rptg = rtg; end
      else begin rpt = ($urandom_range(0, 1) == 1); rptg = AW'($urandom_range(0, 7) << 4); end
      cycle("random");
    end
    idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule